// File: doc/BRIEF.md
# Frame-Synchronous GPIO Bank with Sticky Interrupt

This block manages a bank of general-purpose pins on behalf of a serial audio link controller. Each pin has two configuration bits, a direction bit and a polarity/type bit. Together they make the pin a push-pull output, an open-drain output, an input whose active level is low, or an input whose active level is high. The bank exposes both configuration words as 16-bit registers. Only the low bits that map to real pins are stored. The upper bits always read as zero.

Once per link frame, the controller delivers a word of pin control bits in an output slot. Only bits that belong to output-configured pins are accepted. The accepted values reach the pins at the next frame boundary. At the same boundary the bank samples the pin levels and loads a status word, which the link returns in the next input frame.

An input that sees an edge in its active direction sets a sticky status bit. While any sticky bit is set, the interrupt flag is asserted. Software clears a sticky bit by writing 0 to it.

Top module: `lnk_gpio_bank`

## Requirements
- R1: After reset every pin is an active-high input. Both configuration registers read 0x001F, no pin is driven (pin_o and pin_oe_o are 0), and the slot status, the sticky bits and irq_o are 0.
- R2: The mode of pin i is {dir[i], pol[i]}. Mode 00 is a push-pull output: pin_oe_o[i]=1 and pin_o[i] follows the applied control value.
- R3: Mode 01 is an open-drain output. A value of 0 gives pin_oe_o[i]=1 and pin_o[i]=0. A value of 1 gives pin_oe_o[i]=0, so the pin is released. An open-drain pin never drives pin_o[i] high.
- R4: A control value accepted through ctrl_valid_i changes no pin until the next cycle in which frame_start_i is high. On that clock edge the value is applied.
- R5: A control bit written while its pin is configured as an input (mode 10 or 11) is discarded. If the pin is later switched back to an output, it resumes the value it held before.
- R6: Bits 15:5 of both configuration registers read as zero, whatever was written to them.
- R7: On each frame_start_i edge, slot_sts_o loads one status bit per pin. An input pin reports the raw level of pin_i. An output pin reports the value it was driving before that edge, so a value applied at one boundary is reported at the following one.
- R8: On a frame_start_i edge, an input pin sets its sticky bit when its sampled level moves in its active direction relative to the previous frame's sample. Active-high pins (mode 11) react to 0 to 1, and active-low pins (mode 10) react to 1 to 0. A steady level or an edge in the other direction sets nothing.
- R9: A sts_wr_i write clears every sticky bit whose sts_wdata_i bit is 0 and leaves the others as they are. irq_o is the OR of the sticky bits and stays high until they are all cleared.
- R10: A pin configured as an output never sets its sticky bit, even when its pin_i level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse at each link frame boundary |
| dir_wr_i | input | 1 | Write strobe for the direction register |
| dir_wdata_i | input | 16 | Direction write data (1 = input) |
| pol_wr_i | input | 1 | Write strobe for the polarity/type register |
| pol_wdata_i | input | 16 | Polarity/type write data |
| dir_rdata_o | output | 16 | Direction register readback |
| pol_rdata_o | output | 16 | Polarity/type register readback |
| ctrl_valid_i | input | 1 | Control slot bits valid for this frame |
| ctrl_bits_i | input | 5 | Per-pin control values from the output slot |
| pin_i | input | 5 | Sampled pad levels |
| pin_o | output | 5 | Pad output values |
| pin_oe_o | output | 5 | Pad output enables |
| slot_sts_o | output | 5 | Pin status word for the next input slot |
| sts_wr_i | input | 1 | Write strobe for the sticky status register |
| sts_wdata_i | input | 5 | Sticky write data (0 clears the bit) |
| sticky_o | output | 5 | Sticky status register readback |
| irq_o | output | 1 | Interrupt flag, OR of the sticky bits |

## Verification
A table of direction, polarity and control combinations drives uniform banks in each mode, then mixed banks. The mixed banks show whether the mode decode is made per pin or leaks between neighbours, and whether a released open-drain pin can be told apart from one driven low. Directed sequences hold a control value across idle cycles to show it waits for the boundary. They park a value while the pin is an input to show the write is discarded, and they step the pad levels through rising, falling and steady frames on mixed polarities to show that only active-direction edges set a sticky bit. Partial clears show which sticky bits survive a write. Further sequences show that output pins report their status one frame late and never raise the interrupt.

// File: rtl/lnk_gpio_pkg.sv
package lnk_gpio_pkg;

  typedef enum logic [1:0] {
    PM_PUSH  = 2'b00,
    PM_OPEN  = 2'b01,
    PM_IN_LO = 2'b10,
    PM_IN_HI = 2'b11
  } pin_mode_e;

  function automatic pin_mode_e mode_of(logic dir_b, logic pol_b);
    return pin_mode_e'({dir_b, pol_b});
  endfunction

  function automatic logic mode_is_in(pin_mode_e m);
    return (m == PM_IN_LO) || (m == PM_IN_HI);
  endfunction

endpackage

// File: rtl/lnk_gpio_cfg_regs.sv
module lnk_gpio_cfg_regs
  import lnk_gpio_pkg::*;
#(
  parameter int N     = 5,
  parameter int REG_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dir_wr_i,
  input  logic [REG_W-1:0]         dir_wdata_i,
  input  logic                     pol_wr_i,
  input  logic [REG_W-1:0]         pol_wdata_i,
  output logic [REG_W-1:0]         dir_rdata_o,
  output logic [REG_W-1:0]         pol_rdata_o,
  output pin_mode_e [N-1:0]        mode_o
);
  localparam int PAD_W = REG_W - N;

  logic [N-1:0] dir_q, pol_q;
  logic unused_wdata;
  assign unused_wdata = ^{dir_wdata_i[REG_W-1:N], pol_wdata_i[REG_W-1:N]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      pol_q <= '1;
    end else begin
      if (dir_wr_i) dir_q <= dir_wdata_i[N-1:0];
      if (pol_wr_i) pol_q <= pol_wdata_i[N-1:0];
    end
  end

  assign dir_rdata_o = {{PAD_W{1'b0}}, dir_q};
  assign pol_rdata_o = {{PAD_W{1'b0}}, pol_q};

  for (genvar i = 0; i < N; i++) begin : g_mode
    assign mode_o[i] = mode_of(dir_q[i], pol_q[i]);
  end
endmodule

// File: rtl/lnk_gpio_out_stage.sv
module lnk_gpio_out_stage
  import lnk_gpio_pkg::*;
#(
  parameter int N = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              ctrl_valid_i,
  input  logic [N-1:0]      ctrl_bits_i,
  input  pin_mode_e [N-1:0] mode_i,
  output logic [N-1:0]      out_val_o,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe_o
);
  logic [N-1:0] pend_q, out_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    // input-mode pins keep their parked value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        out_q[i]  <= 1'b0;
      end else begin
        if (ctrl_valid_i && !mode_is_in(mode_i[i])) pend_q[i] <= ctrl_bits_i[i];
        if (frame_start_i) out_q[i] <= pend_q[i];
      end
    end

    always_comb begin
      unique case (mode_i[i])
        PM_PUSH: begin pin_o[i] = out_q[i]; pin_oe_o[i] = 1'b1;      end
        PM_OPEN: begin pin_o[i] = 1'b0;     pin_oe_o[i] = ~out_q[i]; end
        default: begin pin_o[i] = 1'b0;     pin_oe_o[i] = 1'b0;      end
      endcase
    end
  end

  assign out_val_o = out_q;
endmodule

// File: rtl/lnk_gpio_in_stage.sv
module lnk_gpio_in_stage
  import lnk_gpio_pkg::*;
#(
  parameter int N = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [N-1:0]      pin_i,
  input  pin_mode_e [N-1:0] mode_i,
  input  logic [N-1:0]      out_val_i,
  input  logic              sts_wr_i,
  input  logic [N-1:0]      sts_wdata_i,
  output logic [N-1:0]      slot_sts_o,
  output logic [N-1:0]      sticky_o,
  output logic              irq_o
);
  logic [N-1:0] lvl_q, sts_q, sticky_q, evt;
  logic         primed_q;

  for (genvar i = 0; i < N; i++) begin : g_evt
    always_comb begin
      evt[i] = 1'b0;
      if (frame_start_i && primed_q) begin
        if (mode_i[i] == PM_IN_HI) evt[i] = !lvl_q[i] &&  pin_i[i];
        if (mode_i[i] == PM_IN_LO) evt[i] =  lvl_q[i] && !pin_i[i];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[i] <= 1'b0;
      else if (frame_start_i)
        sts_q[i] <= mode_is_in(mode_i[i]) ? pin_i[i] : out_val_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= '0;
      primed_q <= 1'b0;
      sticky_q <= '0;
    end else begin
      if (frame_start_i) begin
        lvl_q    <= pin_i;
        primed_q <= 1'b1;
      end
      // a new event wins over a clear in the same cycle
      sticky_q <= (sticky_q & (sts_wr_i ? sts_wdata_i : '1)) | evt;
    end
  end

  assign slot_sts_o = sts_q;
  assign sticky_o   = sticky_q;
  assign irq_o      = |sticky_q;
endmodule

// File: rtl/lnk_gpio_bank.sv
module lnk_gpio_bank
  import lnk_gpio_pkg::*;
#(
  parameter int N     = 5,
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             dir_wr_i,
  input  logic [REG_W-1:0] dir_wdata_i,
  input  logic             pol_wr_i,
  input  logic [REG_W-1:0] pol_wdata_i,
  output logic [REG_W-1:0] dir_rdata_o,
  output logic [REG_W-1:0] pol_rdata_o,
  input  logic             ctrl_valid_i,
  input  logic [N-1:0]     ctrl_bits_i,
  input  logic [N-1:0]     pin_i,
  output logic [N-1:0]     pin_o,
  output logic [N-1:0]     pin_oe_o,
  output logic [N-1:0]     slot_sts_o,
  input  logic             sts_wr_i,
  input  logic [N-1:0]     sts_wdata_i,
  output logic [N-1:0]     sticky_o,
  output logic             irq_o
);
  pin_mode_e [N-1:0] mode;
  logic [N-1:0]      out_val;

  lnk_gpio_cfg_regs #(.N(N), .REG_W(REG_W)) u_cfg (
    .clk_i, .rst_ni, .dir_wr_i, .dir_wdata_i, .pol_wr_i, .pol_wdata_i,
    .dir_rdata_o, .pol_rdata_o, .mode_o(mode)
  );

  lnk_gpio_out_stage #(.N(N)) u_out (
    .clk_i, .rst_ni, .frame_start_i, .ctrl_valid_i, .ctrl_bits_i,
    .mode_i(mode), .out_val_o(out_val), .pin_o, .pin_oe_o
  );

  lnk_gpio_in_stage #(.N(N)) u_in (
    .clk_i, .rst_ni, .frame_start_i, .pin_i, .mode_i(mode),
    .out_val_i(out_val), .sts_wr_i, .sts_wdata_i,
    .slot_sts_o, .sticky_o, .irq_o
  );
endmodule

// File: rtl/lnk_gpio_bank_chk.sv
module lnk_gpio_bank_chk #(
  parameter int N     = 5,
  parameter int REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             dir_wr_i,
  input logic             pol_wr_i,
  input logic [REG_W-1:0] dir_rdata_o,
  input logic [REG_W-1:0] pol_rdata_o,
  input logic [N-1:0]     pin_o,
  input logic [N-1:0]     pin_oe_o,
  input logic [N-1:0]     slot_sts_o,
  input logic             sts_wr_i,
  input logic [N-1:0]     sticky_o,
  input logic             irq_o
);
  logic [N-1:0] dir_b, pol_b;
  assign dir_b = dir_rdata_o[N-1:0];
  assign pol_b = pol_rdata_o[N-1:0];

  assert_in_undriven_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & dir_b) == '0);

  assert_push_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~dir_b & ~pol_b & ~pin_oe_o) == '0);

  assert_open_never_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~dir_b & pol_b & pin_o) == '0);

  assert_hold_between_frames_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && !dir_wr_i && !pol_wr_i) |=> $stable(pin_o));

  assert_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rdata_o[REG_W-1:N] == '0) && (pol_rdata_o[REG_W-1:N] == '0));

  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(slot_sts_o));

  assert_set_on_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ((sticky_o & ~$past(sticky_o)) == '0));

  assert_clear_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr_i |=> (($past(sticky_o) & ~sticky_o) == '0));

  assert_irq_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !sts_wr_i) |=> irq_o);
endmodule

bind lnk_gpio_bank lnk_gpio_bank_chk #(.N(N), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_lnk_gpio_bank.sv
module sim_lnk_gpio_bank;
  localparam int N = 5;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, dir_wr = 1'b0, pol_wr = 1'b0, ctrl_valid = 1'b0, sts_wr = 1'b0;
  logic [W-1:0] dir_wdata = '0, pol_wdata = '0;
  logic [W-1:0] dir_rdata, pol_rdata;
  logic [N-1:0] ctrl_bits = '0, pin_in = '0, sts_wdata = '0;
  logic [N-1:0] pin_out, pin_oe, slot_sts, sticky;
  logic irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lnk_gpio_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start),
    .dir_wr_i(dir_wr), .dir_wdata_i(dir_wdata), .pol_wr_i(pol_wr), .pol_wdata_i(pol_wdata),
    .dir_rdata_o(dir_rdata), .pol_rdata_o(pol_rdata),
    .ctrl_valid_i(ctrl_valid), .ctrl_bits_i(ctrl_bits), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .slot_sts_o(slot_sts),
    .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata), .sticky_o(sticky), .irq_o(irq)
  );

  // {dir, pol, ctrl, exp pin_o, exp pin_oe}
  localparam logic [24:0] VEC [6] = '{
    {5'b00000, 5'b00000, 5'b10110, 5'b10110, 5'b11111},
    {5'b00000, 5'b11111, 5'b10110, 5'b00000, 5'b01001},
    {5'b11111, 5'b11111, 5'b11111, 5'b00000, 5'b00000},
    {5'b10100, 5'b01010, 5'b01011, 5'b00001, 5'b00001},
    {5'b00011, 5'b00100, 5'b11000, 5'b11000, 5'b11100},
    {5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b11111}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr_cfg(logic [W-1:0] d, logic [W-1:0] p);
    dir_wr = 1'b1; dir_wdata = d; pol_wr = 1'b1; pol_wdata = p;
    cyc();
    dir_wr = 1'b0; pol_wr = 1'b0;
  endtask

  task automatic wr_ctrl(logic [N-1:0] v);
    ctrl_valid = 1'b1; ctrl_bits = v;
    cyc();
    ctrl_valid = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    cyc();
    frame_start = 1'b0;
  endtask

  task automatic wr_sts(logic [N-1:0] v);
    sts_wr = 1'b1; sts_wdata = v;
    cyc();
    sts_wr = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 dir", dir_rdata, 32'h001F);
    check("R1 pol", pol_rdata, 32'h001F);
    check("R1 pin", {pin_oe, pin_out}, 0);
    check("R1 sts", {irq, sticky, slot_sts}, 0);

    // R2/R3 mode table
    for (int k = 0; k < 6; k++) begin
      logic [24:0] v;
      v = VEC[k];
      wr_cfg({11'b0, v[24:20]}, {11'b0, v[19:15]});
      wr_ctrl(v[14:10]);
      frame();
      check("R2/R3 pin_o", pin_out, v[9:5]);
      check("R2/R3 pin_oe", pin_oe, v[4:0]);
    end

    // R6 upper bits read zero
    wr_cfg(16'hFFFF, 16'hABCD);
    check("R6 dir", dir_rdata, 32'h001F);
    check("R6 pol", pol_rdata, 32'h000D);

    // R4 deferred apply
    wr_cfg(16'h0000, 16'h0000);
    wr_ctrl(5'b11111);
    frame();
    check("R4 first", pin_out, 5'b11111);
    wr_ctrl(5'b00000);
    repeat (3) cyc();
    check("R4 held", pin_out, 5'b11111);
    frame();
    check("R4 applied", pin_out, 5'b00000);

    // R5 writes to input pins discarded
    wr_cfg(16'h001E, 16'h001E);
    wr_ctrl(5'b00001);
    frame();
    check("R5 drive", pin_out, 5'b00001);
    wr_cfg(16'h001F, 16'h001F);
    check("R5 input", pin_oe, 5'b00000);
    wr_ctrl(5'b00000);
    frame();
    wr_cfg(16'h001E, 16'h001E);
    check("R5 kept pin", pin_out, 5'b00001);
    check("R5 kept oe", pin_oe, 5'b00001);

    // R7 slot status, outputs one frame late
    wr_cfg(16'h001C, 16'h001C);
    wr_ctrl(5'b00011);
    frame();
    wr_ctrl(5'b00010);
    pin_in = 5'b10100;
    frame();
    check("R7 frame B", slot_sts, 5'b10111);
    frame();
    check("R7 frame C", slot_sts, 5'b10110);

    // R8 edge polarity, pin0 active low
    wr_cfg(16'h001F, 16'h001E);
    pin_in = 5'b00001;
    frame();
    frame();
    wr_sts(5'b00000);
    frame();
    check("R8 steady", sticky, 5'b00000);
    pin_in = 5'b00010;
    frame();
    check("R8 active edges", sticky, 5'b00011);
    check("R9 irq set", irq, 1'b1);

    // R9 partial clear and hold
    wr_sts(5'b00010);
    check("R9 partial", sticky, 5'b00010);
    repeat (4) cyc();
    check("R9 irq held", irq, 1'b1);
    wr_sts(5'b00000);
    check("R9 cleared", {irq, sticky}, 6'b0);

    pin_in = 5'b00001;
    frame();
    check("R8 inactive edges", sticky, 5'b00000);

    // R10 output pins never set sticky
    wr_cfg(16'h001B, 16'h001B);
    pin_in = 5'b00000;
    frame();
    wr_sts(5'b00000);
    pin_in = 5'b00100;
    frame();
    check("R10 output edge", {irq, sticky}, 6'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule